// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers a set of level-sensitive, active-high interrupt sources and fans them out to four request lines: one ordinary interrupt request and one machine-check request for each of two processor cores. Every source is first passed through a multi-flop synchroniser. The synchronised levels can be read at any time through a read-only status word on a simple 32-bit register bus. The bus has an address, a write enable, write data and combinational read data.

Each of the four outputs has its own enable mask. An output is the registered OR, over all sources, of the synchronised level ANDed with that output's mask. The masks are independent. One source may be routed to any combination of the four lines, and every enabled line asserts together. Nothing is latched and nothing is acknowledged. A line stays high as long as an enabled source stays high. It falls only when the source drops or its mask bit is cleared. Choosing which source to service is left to software, which reads the status word and the masks.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all four mask registers read zero and `coreIrq` and `coreMchk` are all low.
- R2: A read at byte offset 0x00 returns the synchronised source levels, with bit n equal to `srcLevel[n]`. A level change appears there two clock edges after it is presented.
- R3: The interrupt mask of core c (c = 0 or 1) is at byte offset 0x10 + 4*c. A write to it stores the whole word, and a read returns the last value written.
- R4: The machine-check mask of core c is at byte offset 0x18 + 4*c. It has the same write and read-back behaviour as R3.
- R5: `coreIrq[c]` is high exactly when some source n has its synchronised level high and bit n of core c's interrupt mask set. A mask bit of 1 enables the source, and 0 blocks it.
- R6: `coreMchk[c]` follows the same rule as R5, using core c's machine-check mask.
- R7: The masks are not exclusive. A source that is enabled in several masks drives every one of those outputs high at the same time.
- R8: There is no acknowledge. An asserted output stays high while an enabled source stays high. It falls one clock edge after its mask bit is cleared, or three edges after the source goes low.
- R9: Writes to offset 0x00 or to any unmapped offset (including unaligned ones) change no mask. Reads of unmapped offsets return zero.
- R10: Each output is registered. It changes one clock edge after a mask write, and three clock edges after a source change: two synchroniser edges and then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 32 | Level-sensitive interrupt sources, active high |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| coreIrq | output | 2 | Interrupt request to each core |
| coreMchk | output | 2 | Machine-check request to each core |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit word, a two-flop synchroniser and an 8-bit byte address. With full-width masks, random 32-bit source and mask patterns reach every bit position, including the top bit and the single-bit overlaps that decide the OR. The fixed two-stage synchroniser pins the source-to-output latency at three edges, so directed checks can sample the edge before the change and the edge after it. The 8-bit address space also leaves room for unaligned and out-of-range offsets, which are used to test ignored writes and zero reads.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Number of cores served; the register map places one mask of each kind per core.
  localparam int NUM_CORE = 2;

  // Byte offsets of the register map.
  localparam int OFS_STATUS    = 'h00;
  localparam int OFS_IRQ_BASE  = 'h10;
  localparam int OFS_MCHK_BASE = 'h18;
  localparam int OFS_STRIDE    = 4;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic [NUM_CORE-1:0] irqWe;
    logic [NUM_CORE-1:0] mchkWe;
    logic                rdStatus;
    logic [NUM_CORE-1:0] rdIrq;
    logic [NUM_CORE-1:0] rdMchk;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);

  // Exact-match decode: unaligned or unlisted offsets select nothing.
  always_comb begin
    strobe = '0;
    strobe.rdStatus = (busAddr == ADDR_W'(OFS_STATUS));
    for (int c = 0; c < NUM_CORE; c++) begin
      if (busAddr == ADDR_W'(OFS_IRQ_BASE + OFS_STRIDE * c)) begin
        strobe.rdIrq[c] = 1'b1;
        strobe.irqWe[c] = busWrEn;
      end
      if (busAddr == ADDR_W'(OFS_MCHK_BASE + OFS_STRIDE * c)) begin
        strobe.rdMchk[c] = 1'b1;
        strobe.mchkWe[c] = busWrEn;
      end
    end
  end

endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] status,
  input  logic [DATA_W-1:0]  busWrData,
  input  ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_CORE-1:0] coreIrq,
  output logic [NUM_CORE-1:0] coreMchk
);

  logic [NUM_SRC-1:0] irqMask  [NUM_CORE];
  logic [NUM_SRC-1:0] mchkMask [NUM_CORE];
  logic [NUM_SRC-1:0] wrMask;

  assign wrMask = busWrData[NUM_SRC-1:0];

  // Mask registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORE; c++) begin
        irqMask[c]  <= '0;
        mchkMask[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CORE; c++) begin
        if (strobe.irqWe[c])  irqMask[c]  <= wrMask;
        if (strobe.mchkWe[c]) mchkMask[c] <= wrMask;
      end
    end
  end

  // Registered request outputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreIrq  <= '0;
      coreMchk <= '0;
    end else begin
      for (int c = 0; c < NUM_CORE; c++) begin
        coreIrq[c]  <= |(status & irqMask[c]);
        coreMchk[c] <= |(status & mchkMask[c]);
      end
    end
  end

  // Read mux: decoder strobes are exclusive, so OR-combine.
  always_comb begin
    busRdData = '0;
    if (strobe.rdStatus) busRdData = busRdData | DATA_W'(status);
    for (int c = 0; c < NUM_CORE; c++) begin
      if (strobe.rdIrq[c])  busRdData = busRdData | DATA_W'(irqMask[c]);
      if (strobe.rdMchk[c]) busRdData = busRdData | DATA_W'(mchkMask[c]);
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (coreIrq == '0 && coreMchk == '0));

  for (genvar g = 0; g < NUM_CORE; g++) begin : gChk
    a_r3_irq_mask_lands: assert property (@(posedge clk) disable iff (!rstN)
      strobe.irqWe[g] |=> irqMask[g] == $past(wrMask));
    a_r4_mchk_mask_lands: assert property (@(posedge clk) disable iff (!rstN)
      strobe.mchkWe[g] |=> mchkMask[g] == $past(wrMask));
    a_r9_irq_mask_kept: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.irqWe[g] |=> $stable(irqMask[g]));
    a_r9_mchk_mask_kept: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.mchkWe[g] |=> $stable(mchkMask[g]));
    a_r8_irq_no_self_clear: assert property (@(posedge clk) disable iff (!rstN)
      (coreIrq[g] && (status & irqMask[g]) != '0) |=> coreIrq[g]);
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcLevel,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_CORE-1:0] coreIrq,
  output logic [NUM_CORE-1:0] coreMchk
);

  logic [NUM_SRC-1:0] syncLevel;
  ctrlStrobe_t        strobe;

  irqagg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (srcLevel),
    .dout (syncLevel)
  );

  irqagg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  irqagg_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .status    (syncLevel),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .coreIrq   (coreIrq),
    .coreMchk  (coreMchk)
  );

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcLevel = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [1:0]  coreIrq, coreMchk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mIrq [2];
  logic [31:0] mMchk [2];
  logic [31:0] lv;

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .coreIrq(coreIrq), .coreMchk(coreMchk)
  );

  function automatic logic hit(input logic [31:0] l, input logic [31:0] m);
    return |(l & m);
  endfunction

  function automatic logic [7:0] irqOfs(input int c);
    return 8'(8'h10 + 4 * c);
  endfunction

  function automatic logic [7:0] mchkOfs(input int c);
    return 8'(8'h18 + 4 * c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcLevel = v; lv = v;
  endtask

  task automatic checkOutputs(input string req);
    chk(req, {30'd0, coreIrq},
        {30'd0, hit(lv, mIrq[1]), hit(lv, mIrq[0])});
    chk(req, {30'd0, coreMchk},
        {30'd0, hit(lv, mMchk[1]), hit(lv, mMchk[0])});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    lv = '0;
    for (int c = 0; c < 2; c++) begin mIrq[c] = '0; mMchk[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state.
    @(negedge clk);
    chk("R1 irq", {30'd0, coreIrq}, 32'd0);
    chk("R1 mchk", {30'd0, coreMchk}, 32'd0);
    for (int c = 0; c < 2; c++) begin
      busRead(irqOfs(c), rd);  chk("R1 irq mask", rd, 32'd0);
      busRead(mchkOfs(c), rd); chk("R1 mchk mask", rd, 32'd0);
    end

    // R3/R4: readback of every mask.
    busWrite(irqOfs(0), 32'hA5A5_0001); mIrq[0] = 32'hA5A5_0001;
    busWrite(irqOfs(1), 32'h8000_0000); mIrq[1] = 32'h8000_0000;
    busWrite(mchkOfs(0), 32'h0000_0020); mMchk[0] = 32'h0000_0020;
    busWrite(mchkOfs(1), 32'hFFFF_FFFF); mMchk[1] = 32'hFFFF_FFFF;
    busRead(irqOfs(0), rd);  chk("R3 core0", rd, mIrq[0]);
    busRead(irqOfs(1), rd);  chk("R3 core1", rd, mIrq[1]);
    busRead(mchkOfs(0), rd); chk("R4 core0", rd, mMchk[0]);
    busRead(mchkOfs(1), rd); chk("R4 core1", rd, mMchk[1]);

    // R10/R2: latency of a source change (bit 0 enabled only on irq0 and mchk1).
    setSrc(32'h0000_0001);
    @(posedge clk); @(negedge clk);
    busAddr = 8'h00; #1 chk("R2 status after one edge", busRdData, 32'd0);
    @(posedge clk); @(negedge clk);
    busAddr = 8'h00; #1 chk("R2 status after two edges", busRdData, 32'h1);
    chk("R10 irq0 not yet", {31'd0, coreIrq[0]}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 irq0 third edge", {31'd0, coreIrq[0]}, 32'd1);
    checkOutputs("R5 R6");

    // R8: stays up while high, drops one edge after mask cleared.
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R8 held", {31'd0, coreIrq[0]}, 32'd1);
    busWrite(irqOfs(0), 32'h0); mIrq[0] = 32'h0;
    chk("R8 old mask still used", {31'd0, coreIrq[0]}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 dropped after mask clear", {31'd0, coreIrq[0]}, 32'd0);
    // R8: source low drops mchk1 after three edges.
    setSrc(32'h0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 mchk1 before drop", {31'd0, coreMchk[1]}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 mchk1 after drop", {31'd0, coreMchk[1]}, 32'd0);

    // R7: one source in all four masks.
    for (int c = 0; c < 2; c++) begin
      busWrite(irqOfs(c), 32'h0004_0000); mIrq[c] = 32'h0004_0000;
      busWrite(mchkOfs(c), 32'h0004_0000); mMchk[c] = 32'h0004_0000;
    end
    setSrc(32'h0004_0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 all irq", {30'd0, coreIrq}, 32'd3);
    chk("R7 all mchk", {30'd0, coreMchk}, 32'd3);

    // R9: ignored writes and zero reads.
    busWrite(8'h00, 32'hDEAD_BEEF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h11, 32'hFFFF_FFFF);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'hFC, 32'hFFFF_FFFF);
    for (int c = 0; c < 2; c++) begin
      busRead(irqOfs(c), rd);  chk("R9 irq mask kept", rd, mIrq[c]);
      busRead(mchkOfs(c), rd); chk("R9 mchk mask kept", rd, mMchk[c]);
    end
    busRead(8'h00, rd); chk("R9 status not written", rd, lv);
    busRead(8'h04, rd); chk("R9 unmapped read", rd, 32'd0);
    busRead(8'h13, rd); chk("R9 unaligned read", rd, 32'd0);
    busRead(8'h20, rd); chk("R9 beyond map read", rd, 32'd0);

    // Random mix: R2 R3 R4 R5 R6.
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 3);
      if (op != 1) setSrc($urandom & $urandom);
      if (op != 0) begin
        int c;
        logic [31:0] d;
        c = int'($urandom % 2);
        d = $urandom & $urandom;
        if ($urandom % 2 == 0) begin busWrite(irqOfs(c), d); mIrq[c] = d; end
        else begin busWrite(mchkOfs(c), d); mMchk[c] = d; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checkOutputs("R5 R6 random");
      busRead(8'h00, rd); chk("R2 random status", rd, lv);
      busRead(irqOfs(i % 2), rd); chk("R3 random readback", rd, mIrq[i % 2]);
      busRead(mchkOfs(i % 2), rd); chk("R4 random readback", rd, mMchk[i % 2]);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule